// File: doc/BRIEF.md
# Gated 16-bit Timer/Counter

This block is a 16-bit up-counter, read and written one byte at a time. The count can advance on one of four clock sources. Each source is seen as a single-cycle tick in the system clock domain. A prescaler then divides the ticks by 1, 2, 4 or 8. A timer-on bit lets the count advance at all.

When gating is enabled, a gate condition also controls counting. The gate is picked from four inputs and can be inverted. It can be used as a level, or as a toggle that stays open for one full gate period. It can also be used in a one-shot acquisition mode. In that mode a software-armed GO bit lets exactly one gate pulse through, and the hardware then clears the bit.

Rollover past the top count sets a sticky overflow flag. A completed one-shot acquisition sets a gate flag. Software reads the processed gate level from a status bit.

Top module: `gated_timer16`

## Requirements
- R1: After reset every readable register (addresses 0 to 4) reads 0x00 and both flag outputs are low.
- R2: Address 0 holds the low count byte and address 1 the high byte, both writable and readable. A write to either byte takes priority over an increment in the same cycle and leaves the other byte as it was.
- R3: Control register (address 2) layout: bit0 is timer-on, bits 2:1 are the clock select, bits 4:3 the prescale and bit5 the external sync enable. With clock select 00 (system clock) and prescale 00, the count rises by one per cycle while timer-on is 1, and it holds while timer-on is 0.
- R4: Prescale code p divides the selected ticks by 2^p. Any write to the control register restarts the prescaler phase at zero, and the prescaler holds while timer-on is 0.
- R5: Clock select 01 counts cycles with div4_tick high. Select 10 counts rising edges of ext_clk, through a two-flop synchronizer when bit5 is 1 or a single flop when it is 0. Select 11 counts rising edges of aux_clk.
- R6: Gate register (address 3) layout: bit0 gate enable, bit1 polarity, bit2 toggle, bit3 one-shot, bit4 GO, bit5 gate level (read-only), bits 7:6 source. Source 00 is gate_pin, 01 peer_ovf, 10 cmp1_out and 11 cmp2_out. With gating enabled, the count advances only while the sampled gate is active, once per cycle it is held high.
- R7: Polarity 1 inverts the sampled gate, so counting happens while the source is low.
- R8: In toggle mode each rising edge of the gate flips the count enable. The count over two rising edges equals the cycle distance between them.
- R9: In one-shot mode with GO set, counting covers exactly the next full gate pulse. When that pulse ends, GO clears and the gate flag (address 4 bit1, and port gate_flag) sets. Later pulses are not counted.
- R10: An increment from 0xFFFF to 0x0000 sets the overflow flag (address 4 bit0, and port ovf_flag). The flag stays set until software writes a 0 to that bit.
- R11: Gate register bit5 reads the current processed gate level: the sampled source after polarity, or the toggle state in toggle mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| div4_tick | input | 1 | One-cycle enable at a quarter of the system rate |
| ext_clk | input | 1 | External clock pin, asynchronous |
| aux_clk | input | 1 | Auxiliary sensing clock |
| peer_ovf | input | 1 | Overflow pulse from another timer, a gate source |
| cmp1_out | input | 1 | Comparator 1 output, a gate source |
| cmp2_out | input | 1 | Comparator 2 output, a gate source |
| gate_pin | input | 1 | Gate input pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| ovf_flag | output | 1 | Sticky overflow flag |
| gate_flag | output | 1 | Sticky one-shot completion flag |

## Verification
A register write takes effect at the clock edge that samples it, and a timer-on write lets counting start one edge later. So with the system clock source and a run of N idle cycles between the start and stop writes, the count rises by N+2, and the prescaled result is (N+2)>>p.

A gate input changed before edge X is sampled at X and counts from X+1. A gate held high for M cycles therefore adds exactly M, and the toggle path adds one flop on each edge, which cancels out.

The edge-counted sources are checked only on totals after a settle time longer than the synchronizer delay. Read results are queued by the driver and compared on the falling edge of the same cycle, after all counting has stopped.

// File: rtl/gated_timer16.sv
module gated_timer16 #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       div4_tick,
  input  logic       ext_clk,
  input  logic       aux_clk,
  input  logic       peer_ovf,
  input  logic       cmp1_out,
  input  logic       cmp2_out,
  input  logic       gate_pin,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       ovf_flag,
  output logic       gate_flag
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt;
  logic [PS_W-1:0]  pcnt, pmask;
  logic [1:0] clk_sel, psc, g_src;
  logic run_on, ext_sync;
  logic g_en, g_pol, g_tog, g_sp, g_go;
  logic s1, s2, e_prev, a1, a_prev;
  logic gsamp, gsel_q, t_ff, g_q, sp_act;
  logic e_src, src_tick, gate_raw, gsel, g, g_rise, g_fall;
  logic gate_ok, pre_tick, inc, sp_done;

  wire wr_lo  = wr_en && wr_addr == 3'd0;
  wire wr_hi  = wr_en && wr_addr == 3'd1;
  wire wr_ctl = wr_en && wr_addr == 3'd2;
  wire wr_gt  = wr_en && wr_addr == 3'd3;
  wire wr_flg = wr_en && wr_addr == 3'd4;

  assign e_src = ext_sync ? s2 : s1;

  always_comb begin
    case (clk_sel)
      2'd0:    src_tick = 1'b1;
      2'd1:    src_tick = div4_tick;
      2'd2:    src_tick = e_src & ~e_prev;
      default: src_tick = a1 & ~a_prev;
    endcase
    case (g_src)
      2'd0:    gate_raw = gate_pin;
      2'd1:    gate_raw = peer_ovf;
      2'd2:    gate_raw = cmp1_out;
      default: gate_raw = cmp2_out;
    endcase
  end

  assign pmask    = PS_W'((4'd1 << psc) - 4'd1);
  assign pre_tick = run_on & src_tick & ((pcnt & pmask) == pmask);
  assign gsel     = gsamp ^ g_pol;
  assign g        = g_tog ? t_ff : gsel;
  assign g_rise   = g & ~g_q;
  assign g_fall   = ~g & g_q;
  assign gate_ok  = !g_en || (g_sp ? (g_go && g && (g_rise || sp_act)) : g);
  assign inc      = pre_tick & gate_ok;
  assign sp_done  = g_sp & g_go & sp_act & g_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; pcnt <= '0;
      run_on <= 1'b0; clk_sel <= '0; psc <= '0; ext_sync <= 1'b0;
      g_en <= 1'b0; g_pol <= 1'b0; g_tog <= 1'b0; g_sp <= 1'b0; g_go <= 1'b0; g_src <= '0;
      s1 <= 1'b0; s2 <= 1'b0; e_prev <= 1'b0; a1 <= 1'b0; a_prev <= 1'b0;
      gsamp <= 1'b0; gsel_q <= 1'b0; t_ff <= 1'b0; g_q <= 1'b0; sp_act <= 1'b0;
      ovf_flag <= 1'b0; gate_flag <= 1'b0;
    end else begin
      s1 <= ext_clk; s2 <= s1; e_prev <= e_src;
      a1 <= aux_clk; a_prev <= a1;
      gsamp <= gate_raw; gsel_q <= gsel; g_q <= g;

      if (wr_lo || wr_hi) begin
        if (wr_lo) cnt[7:0] <= wr_data;
        if (wr_hi) cnt[15:8] <= wr_data;
      end else if (inc) begin
        cnt <= cnt + 1'b1;
      end

      if (wr_ctl) begin
        pcnt <= '0;
        {ext_sync, psc, clk_sel, run_on} <= wr_data[5:0];
      end else if (run_on && src_tick) begin
        pcnt <= pcnt + 1'b1;
      end

      if (wr_gt) begin
        {g_src} <= wr_data[7:6];
        {g_go, g_sp, g_tog, g_pol, g_en} <= wr_data[4:0];
      end else if (sp_done) begin
        g_go <= 1'b0;
      end

      if (!g_tog)                t_ff <= 1'b0;
      else if (gsel && !gsel_q)  t_ff <= ~t_ff;

      if (!g_sp || !g_go || g_fall) sp_act <= 1'b0;
      else if (g_rise)              sp_act <= 1'b1;

      ovf_flag  <= (wr_flg ? wr_data[0] : ovf_flag)
                   | (inc && !wr_lo && !wr_hi && cnt == TOP);
      gate_flag <= (wr_flg ? wr_data[1] : gate_flag) | sp_done;
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = cnt[7:0];
      3'd1:    rd_data = cnt[15:8];
      3'd2:    rd_data = {2'b00, ext_sync, psc, clk_sel, run_on};
      3'd3:    rd_data = {g_src, g, g_go, g_sp, g_tog, g_pol, g_en};
      3'd4:    rd_data = {6'b0, gate_flag, ovf_flag};
      default: rd_data = 8'h00;
    endcase
  end

  assert_write_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> cnt[7:0] == $past(wr_data));
  assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_on && !wr_lo && !wr_hi) |=> $stable(cnt));
  assert_prescaler_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_on && !wr_ctl) |=> $stable(pcnt));
  assert_gate_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (g_en && !g_sp && !g && !wr_lo && !wr_hi) |=> $stable(cnt));
  assert_go_clear_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (g_go && !wr_gt) |=> (g_go || gate_flag));
  assert_wrap_sets_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == TOP && !wr_lo && !wr_hi && !wr_flg) |=> (cnt == TOP || ovf_flag));
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !wr_flg) |=> ovf_flag);
endmodule

// File: tb/gated_timer16_test.sv
module gated_timer16_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic div4_tick = 0, ext_clk = 0, aux_clk = 0, peer_ovf = 0, cmp1_out = 0, cmp2_out = 0, gate_pin = 0;
  logic wr_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic ovf_flag, gate_flag;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] mon_e;
  string mon_t;

  gated_timer16 uut (.clk(clk), .rst_n(rst_n), .div4_tick(div4_tick), .ext_clk(ext_clk),
    .aux_clk(aux_clk), .peer_ovf(peer_ovf), .cmp1_out(cmp1_out), .cmp2_out(cmp2_out),
    .gate_pin(gate_pin), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ovf_flag(ovf_flag), .gate_flag(gate_flag));

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      mon_e = exp_q.pop_front();
      mon_t = tag_q.pop_front();
      checks++;
      if (rd_data !== mon_e) begin
        fails++;
        $display("FAIL %s: got %h expected %h", mon_t, rd_data, mon_e);
      end
    end
  end

  task automatic expect_rd(input logic [2:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    rd_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic expect_cnt(input logic [15:0] e, input string t);
    expect_rd(3'd0, e[7:0], t);
    expect_rd(3'd1, e[15:8], t);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic clear_all();
    wr(3'd2, 8'h00); wr(3'd0, 8'h00); wr(3'd1, 8'h00);
  endtask

  task automatic hold_gate(input int which, input int m);
    @(negedge clk);
    case (which) 0: gate_pin = 1; 1: peer_ovf = 1; 2: cmp1_out = 1; default: cmp2_out = 1; endcase
    repeat (m) @(negedge clk);
    gate_pin = 0; peer_ovf = 0; cmp1_out = 0; cmp2_out = 0;
  endtask

  task automatic pulse_clk(input int which, input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      case (which) 1: div4_tick = 1; 2: ext_clk = 1; default: aux_clk = 1; endcase
      if (which == 1) begin @(negedge clk); div4_tick = 0; repeat (2) @(negedge clk); end
      else begin repeat (3) @(negedge clk); ext_clk = 0; aux_clk = 0; repeat (3) @(negedge clk); end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 5; a++) expect_rd(3'(a), 8'h00, "R1 reset register");

    // R2 byte write/readback
    wr(3'd0, 8'hA5); wr(3'd1, 8'h3C);
    expect_cnt(16'h3CA5, "R2 byte readback");

    // R3 system clock, N idle cycles gives N+2 counts, then hold
    clear_all(); wr(3'd0, 8'h10);
    wr(3'd2, 8'h01); repeat (10) @(negedge clk); wr(3'd2, 8'h00);
    expect_cnt(16'h0010 + 16'd12, "R3 sys clock count");
    repeat (5) @(negedge clk);
    expect_cnt(16'h0010 + 16'd12, "R3 hold when off");

    // R4 prescale 2,4,8
    for (int p = 1; p < 4; p++) begin
      clear_all();
      wr(3'd2, 8'h01 | 8'(p << 3)); repeat (38) @(negedge clk); wr(3'd2, 8'h00);
      expect_cnt(16'(40 >> p), "R4 prescale");
    end

    // R2 write priority over increment
    clear_all();
    wr(3'd2, 8'h01); wr(3'd0, 8'h05); wr(3'd2, 8'h00);
    expect_cnt(16'h0007, "R2 write priority");

    // R5 clock sources
    clear_all(); wr(3'd2, 8'h03); pulse_clk(1, 6); repeat (4) @(negedge clk); wr(3'd2, 8'h00);
    expect_cnt(16'd6, "R5 div4 source");
    clear_all(); wr(3'd2, 8'h25); pulse_clk(2, 5); repeat (6) @(negedge clk); wr(3'd2, 8'h00);
    expect_cnt(16'd5, "R5 ext synced");
    clear_all(); wr(3'd2, 8'h05); pulse_clk(2, 4); repeat (6) @(negedge clk); wr(3'd2, 8'h00);
    expect_cnt(16'd4, "R5 ext direct");
    clear_all(); wr(3'd2, 8'h07); pulse_clk(3, 3); repeat (6) @(negedge clk); wr(3'd2, 8'h00);
    expect_cnt(16'd3, "R5 aux source");

    // R6 gate sources, M cycles high gives M counts
    for (int s = 0; s < 4; s++) begin
      clear_all(); wr(3'd3, 8'h01 | 8'(s << 6)); wr(3'd2, 8'h01);
      repeat (3) @(negedge clk); hold_gate(s, 3 + s); repeat (3) @(negedge clk);
      wr(3'd2, 8'h00);
      expect_cnt(16'(3 + s), "R6 gate source");
    end

    // R7 inverted polarity
    gate_pin = 1;
    clear_all(); wr(3'd3, 8'h03); wr(3'd2, 8'h01);
    repeat (4) @(negedge clk);
    @(negedge clk); gate_pin = 0; repeat (5) @(negedge clk); gate_pin = 1;
    repeat (4) @(negedge clk); wr(3'd2, 8'h00);
    expect_cnt(16'd5, "R7 polarity invert");

    // R11 gate level status
    wr(3'd3, 8'h01); repeat (2) @(negedge clk);
    expect_rd(3'd3, 8'h21, "R11 gate level high");
    wr(3'd3, 8'h03);
    expect_rd(3'd3, 8'h03, "R11 gate level inverted");
    gate_pin = 0;

    // R8 toggle mode, distance between rises is W+3
    clear_all(); wr(3'd3, 8'h05); wr(3'd2, 8'h01);
    hold_gate(0, 2); repeat (9) @(negedge clk); hold_gate(0, 2);
    repeat (4) @(negedge clk); wr(3'd2, 8'h00);
    expect_cnt(16'd12, "R8 toggle period");

    // R9 one-shot acquisition
    clear_all(); wr(3'd3, 8'h19); wr(3'd2, 8'h01);
    repeat (2) @(negedge clk); hold_gate(0, 5); repeat (3) @(negedge clk);
    hold_gate(0, 4); repeat (3) @(negedge clk); wr(3'd2, 8'h00);
    expect_cnt(16'd5, "R9 one-shot count");
    expect_rd(3'd3, 8'h09, "R9 GO cleared");
    expect_rd(3'd4, 8'h02, "R9 gate flag set");
    wr(3'd4, 8'h00);
    expect_rd(3'd4, 8'h00, "R9 gate flag cleared");

    // R10 overflow
    wr(3'd3, 8'h00); clear_all();
    wr(3'd0, 8'hFE); wr(3'd1, 8'hFF);
    wr(3'd2, 8'h01); repeat (1) @(negedge clk); wr(3'd2, 8'h00);
    expect_cnt(16'h0001, "R10 wrap count");
    repeat (4) @(negedge clk);
    expect_rd(3'd4, 8'h01, "R10 overflow flag sticky");
    wr(3'd4, 8'h00);
    expect_rd(3'd4, 8'h00, "R10 overflow flag cleared");

    wait (exp_q.size() == 0);
    @(posedge clk); @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule